// File: doc/BRIEF.md
# DMA Start Command Decoder

This block sits between a host register interface and a DMA engine in a SCSI-style bus controller. The host starts a transfer by writing to one of three start addresses. The address selects the transfer type, and the value on the data bus is ignored. Before the write, the host must configure the mode bits that the block watches. These are a DMA enable bit, a target-role bit and a block-mode bit. The block checks the write against those bits and then either starts the transfer or refuses it. A refusal raises a sticky error flag.

While a transfer runs, the block holds three things: the direction, the role and the block-mode setting it captured at the start. It also raises a request toward the DMA engine, which that engine acknowledges. The transfer ends when the end-of-process input pulses or when software clears the DMA enable bit. On that cycle the block emits a one-cycle end event for the interrupt logic. A host read of the initiator-receive address is a status-clear access. It never starts anything, and it clears the error flag.

Top module: `dma_start_decoder`

## Requirements
- R1: After reset, dma_active, dma_req, end_evt and start_err are all 0.
- R2: A write to address 5 while idle, with mode bit 1 (DMA enable) set, starts a send transfer one clock later. In that state dma_active=1 and dma_to_bus=1, and dma_target equals mode bit 6 at the time of the write.
- R3: A write to address 6 while idle, with mode bits 1 and 6 both set, starts a target receive one clock later: dma_active=1, dma_to_bus=0, dma_target=1.
- R4: A write to address 7 while idle, with mode bit 1 set and mode bit 6 clear, starts an initiator receive one clock later: dma_active=1, dma_to_bus=0, dma_target=0.
- R5: The value on host_wdata during a start write has no effect on any output.
- R6: A write to address 5, 6 or 7 while idle whose mode prerequisites are not met starts nothing and sets start_err, which stays set. Writes to addresses 0 to 4 neither start a transfer nor set start_err.
- R7: A read at address 7 never starts a transfer. It clears start_err one clock later. A read at any other address leaves start_err unchanged.
- R8: A start write while dma_active=1 is ignored. Direction, role and block mode stay unchanged, and start_err is not set.
- R9: An eop_pulse while active clears dma_active one clock later. In that same cycle end_evt is 1, and it is 0 again on the following cycle.
- R10: Clearing mode bit 1 while active ends the transfer with the same timing and the same end_evt pulse as R9.
- R11: dma_req rises together with dma_active. It falls one clock after dma_ack is sampled high, and it is always 0 while dma_active=0.
- R12: dma_block takes the value of mode bit 7 at the start write and holds it for the whole transfer, even if mode bit 7 later changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | DATA_W | Host write data (ignored) |
| mode_bits | input | MODE_W | Current mode register contents (bit 1 DMA enable, bit 6 target role, bit 7 block mode) |
| eop_pulse | input | 1 | End-of-process from the DMA side |
| dma_ack | input | 1 | DMA engine acknowledge of the request |
| dma_active | output | 1 | Transfer in progress |
| dma_to_bus | output | 1 | 1 = memory to bus, 0 = bus to memory |
| dma_target | output | 1 | 1 = target role, 0 = initiator role |
| dma_block | output | 1 | Block-mode setting captured at start |
| dma_req | output | 1 | Request toward the DMA engine |
| end_evt | output | 1 | One-cycle pulse when a transfer ends |
| start_err | output | 1 | Sticky flag for a refused start write |

## Verification
The hardest cases to reach are the ones where a start write arrives while a transfer is already running. The bench has to show that this write changes nothing. To do so it first starts a send transfer. It then writes the initiator-receive address with mode bits that would be accepted from idle, and confirms that direction, role and the error flag are unchanged. The block-mode hold is reached the same way: the bench rewrites the mode bits partway through a transfer and checks that the captured value survives.

// File: rtl/dmastart_pkg.sv
package dmastart_pkg;

    // Mode register bit positions watched by the decoder
    localparam int MB_DMA = 1;
    localparam int MB_TGT = 6;
    localparam int MB_BLK = 7;

    // Start addresses (the initiator-receive address doubles as status clear on read)
    localparam int ADR_SEND  = 5;
    localparam int ADR_TRECV = 6;
    localparam int ADR_IRECV = 7;

    typedef enum logic [1:0] {
        XK_NONE  = 2'd0,
        XK_SEND  = 2'd1,
        XK_TRECV = 2'd2,
        XK_IRECV = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic       valid;
        xfer_kind_e kind;
        logic       to_bus;
        logic       target;
        logic       block;
    } start_cmd_t;

    function automatic logic prereq_ok(input xfer_kind_e k, input logic dma_on, input logic tgt);
        logic ok;
        case (k)
            XK_SEND:  ok = dma_on;
            XK_TRECV: ok = dma_on & tgt;
            XK_IRECV: ok = dma_on & ~tgt;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic kind_is_target(input xfer_kind_e k, input logic tgt);
        return (k == XK_TRECV) | ((k == XK_SEND) & tgt);
    endfunction

endpackage

// File: rtl/dms_cmd_decode.sv
module dms_cmd_decode
    import dmastart_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int MODE_W = 8
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [MODE_W-1:0] mode_bits,
    output start_cmd_t        cmd,
    output logic              bad_start,
    output logic              clr_req
);

    localparam logic [ADDR_W-1:0] A_SEND  = ADDR_W'(ADR_SEND);
    localparam logic [ADDR_W-1:0] A_TRECV = ADDR_W'(ADR_TRECV);
    localparam logic [ADDR_W-1:0] A_IRECV = ADDR_W'(ADR_IRECV);

    xfer_kind_e kind;
    logic       ok;
    logic       mode_unused;

    assign mode_unused = ^mode_bits;

    always_comb begin
        kind = XK_NONE;
        if (host_wr) begin
            if (host_addr == A_SEND)       kind = XK_SEND;
            else if (host_addr == A_TRECV) kind = XK_TRECV;
            else if (host_addr == A_IRECV) kind = XK_IRECV;
        end
    end

    assign ok = prereq_ok(kind, mode_bits[MB_DMA], mode_bits[MB_TGT]);

    always_comb begin
        cmd.valid  = (kind != XK_NONE) && ok;
        cmd.kind   = kind;
        cmd.to_bus = (kind == XK_SEND);
        cmd.target = kind_is_target(kind, mode_bits[MB_TGT]);
        cmd.block  = mode_bits[MB_BLK];
    end

    assign bad_start = (kind != XK_NONE) && !ok;
    assign clr_req   = host_rd && (host_addr == A_IRECV);

endmodule

// File: rtl/dms_xfer_track.sv
module dms_xfer_track
    import dmastart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  start_cmd_t cmd,
    input  logic       eop_pulse,
    input  logic       dma_on,
    output logic       active,
    output logic       to_bus,
    output logic       target,
    output logic       block,
    output logic       end_evt,
    output logic       start_fire,
    output logic       stop
);

    logic active_q, to_bus_q, target_q, block_q, end_q;

    assign stop       = active_q & (eop_pulse | ~dma_on);
    assign start_fire = cmd.valid & ~active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            to_bus_q <= 1'b0;
            target_q <= 1'b0;
            block_q  <= 1'b0;
            end_q    <= 1'b0;
        end else begin
            end_q <= stop;
            if (stop) begin
                active_q <= 1'b0;
            end else if (start_fire) begin
                active_q <= 1'b1;
                to_bus_q <= cmd.to_bus;
                target_q <= cmd.target;
                block_q  <= cmd.block;
            end
        end
    end

    assign active  = active_q;
    assign to_bus  = to_bus_q;
    assign target  = target_q;
    assign block   = block_q;
    assign end_evt = end_q;

endmodule

// File: rtl/dms_req_hs.sv
module dms_req_hs (
    input  logic clk,
    input  logic rst,
    input  logic start_fire,
    input  logic stop,
    input  logic ack,
    output logic req
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)                req_q <= 1'b0;
        else if (start_fire)    req_q <= 1'b1;
        else if (ack || stop)   req_q <= 1'b0;
    end

    assign req = req_q;

endmodule

// File: rtl/dms_err_flag.sv
module dms_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

endmodule

// File: rtl/dma_start_decoder.sv
module dma_start_decoder
    import dmastart_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              eop_pulse,
    input  logic              dma_ack,
    output logic              dma_active,
    output logic              dma_to_bus,
    output logic              dma_target,
    output logic              dma_block,
    output logic              dma_req,
    output logic              end_evt,
    output logic              start_err
);

    start_cmd_t cmd;
    logic       bad_start, clr_req, start_fire, stop;
    logic       wdata_unused;

    // Start writes carry no payload
    assign wdata_unused = ^host_wdata;

    dms_cmd_decode #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_dec (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .mode_bits (mode_bits),
        .cmd       (cmd),
        .bad_start (bad_start),
        .clr_req   (clr_req)
    );

    dms_xfer_track u_trk (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .eop_pulse  (eop_pulse),
        .dma_on     (mode_bits[MB_DMA]),
        .active     (dma_active),
        .to_bus     (dma_to_bus),
        .target     (dma_target),
        .block      (dma_block),
        .end_evt    (end_evt),
        .start_fire (start_fire),
        .stop       (stop)
    );

    dms_req_hs u_req (
        .clk        (clk),
        .rst        (rst),
        .start_fire (start_fire),
        .stop       (stop),
        .ack        (dma_ack),
        .req        (dma_req)
    );

    // A refused write only counts as an error when no transfer is running
    dms_err_flag u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (bad_start & ~dma_active),
        .clr  (clr_req),
        .flag (start_err)
    );

endmodule

// File: rtl/dms_checker.sv
module dms_checker (
    input logic clk,
    input logic rst,
    input logic host_wr,
    input logic host_rd,
    input logic eop_pulse,
    input logic dma_active,
    input logic dma_to_bus,
    input logic dma_target,
    input logic dma_block,
    input logic dma_req,
    input logic end_evt,
    input logic start_err
);

    // R2
    start_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_active) |-> $past(host_wr));

    // R6
    err_needs_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_err) |-> $past(host_wr));

    // R7
    read_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && !dma_active) |=> !dma_active);

    // R8
    hold_attrs_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_active && $past(dma_active)) |->
            ($stable(dma_to_bus) && $stable(dma_target) && $stable(dma_block)));

    // R9
    eop_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_active && eop_pulse) |=> (!dma_active && end_evt));

    // R9
    end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        end_evt |-> (!dma_active && $past(dma_active)));

    // R11
    req_in_active_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> dma_active);

endmodule

bind dma_start_decoder dms_checker u_chk (.*);

// File: tb/dma_start_decoder_tb.sv
module dma_start_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] mode_bits = '0;
    logic       eop_pulse = 1'b0;
    logic       dma_ack = 1'b0;
    logic       dma_active, dma_to_bus, dma_target, dma_block, dma_req, end_evt, start_err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_start_decoder u_dut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .mode_bits(mode_bits), .eop_pulse(eop_pulse), .dma_ack(dma_ack),
        .dma_active(dma_active), .dma_to_bus(dma_to_bus), .dma_target(dma_target),
        .dma_block(dma_block), .dma_req(dma_req), .end_evt(end_evt), .start_err(start_err)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic eop_end(input string req);
        @(negedge clk);
        eop_pulse = 1'b1;
        @(negedge clk);
        eop_pulse = 1'b0;
        check(req, "active after eop", {7'd0, dma_active}, 8'd0);
        check(req, "end_evt", {7'd0, end_evt}, 8'd1);
        @(negedge clk);
        check(req, "end_evt drops", {7'd0, end_evt}, 8'd0);
    endtask

    task automatic t_reset();
        check("R1", "active", {7'd0, dma_active}, 8'd0);
        check("R1", "req", {7'd0, dma_req}, 8'd0);
        check("R1", "end_evt", {7'd0, end_evt}, 8'd0);
        check("R1", "err", {7'd0, start_err}, 8'd0);
    endtask

    task automatic t_send();
        mode_bits = 8'h02;
        wr(3'd5, 8'h00);
        check("R2", "active", {7'd0, dma_active}, 8'd1);
        check("R2", "to_bus", {7'd0, dma_to_bus}, 8'd1);
        check("R2", "target", {7'd0, dma_target}, 8'd0);
        check("R11", "req on start", {7'd0, dma_req}, 8'd1);
        eop_end("R9");
        check("R11", "req idle", {7'd0, dma_req}, 8'd0);
        mode_bits = 8'h42;
        wr(3'd5, 8'h00);
        check("R2", "target send", {7'd0, dma_target}, 8'd1);
        check("R2", "to_bus tgt", {7'd0, dma_to_bus}, 8'd1);
        eop_end("R9");
    endtask

    task automatic t_trecv();
        mode_bits = 8'h42;
        wr(3'd6, 8'h00);
        check("R3", "active", {7'd0, dma_active}, 8'd1);
        check("R3", "to_bus", {7'd0, dma_to_bus}, 8'd0);
        check("R3", "target", {7'd0, dma_target}, 8'd1);
        eop_end("R9");
    endtask

    task automatic t_irecv();
        mode_bits = 8'h02;
        wr(3'd7, 8'h00);
        check("R4", "active", {7'd0, dma_active}, 8'd1);
        check("R4", "to_bus", {7'd0, dma_to_bus}, 8'd0);
        check("R4", "target", {7'd0, dma_target}, 8'd0);
        eop_end("R9");
    endtask

    task automatic t_data_ignored();
        mode_bits = 8'h42;
        wr(3'd6, 8'hFF);
        check("R5", "active", {7'd0, dma_active}, 8'd1);
        check("R5", "to_bus", {7'd0, dma_to_bus}, 8'd0);
        check("R5", "target", {7'd0, dma_target}, 8'd1);
        check("R5", "block", {7'd0, dma_block}, 8'd0);
        eop_end("R9");
        mode_bits = 8'h00;
        wr(3'd5, 8'hA5);
        check("R5", "no start", {7'd0, dma_active}, 8'd0);
        rd(3'd7);
    endtask

    task automatic t_prereq();
        mode_bits = 8'h00;
        wr(3'd5, 8'h00);
        check("R6", "send no dma", {7'd0, dma_active}, 8'd0);
        check("R6", "err set", {7'd0, start_err}, 8'd1);
        repeat (3) @(negedge clk);
        check("R6", "err sticky", {7'd0, start_err}, 8'd1);
        rd(3'd5);
        check("R7", "other read keeps err", {7'd0, start_err}, 8'd1);
        rd(3'd7);
        check("R7", "read7 clears err", {7'd0, start_err}, 8'd0);
        mode_bits = 8'h02;
        wr(3'd6, 8'h00);
        check("R6", "trecv no tgt", {7'd0, dma_active}, 8'd0);
        check("R6", "err trecv", {7'd0, start_err}, 8'd1);
        rd(3'd7);
        mode_bits = 8'h42;
        wr(3'd7, 8'h00);
        check("R6", "irecv tgt", {7'd0, dma_active}, 8'd0);
        check("R6", "err irecv", {7'd0, start_err}, 8'd1);
        rd(3'd7);
        for (int a = 0; a < 5; a++) begin
            wr(a[2:0], 8'h00);
            check("R6", "low addr no start", {7'd0, dma_active}, 8'd0);
            check("R6", "low addr no err", {7'd0, start_err}, 8'd0);
        end
    endtask

    task automatic t_read7();
        mode_bits = 8'h02;
        rd(3'd7);
        check("R7", "read no start", {7'd0, dma_active}, 8'd0);
        @(negedge clk);
        check("R7", "still idle", {7'd0, dma_active}, 8'd0);
    endtask

    task automatic t_second_start();
        mode_bits = 8'h02;
        wr(3'd5, 8'h00);
        wr(3'd7, 8'h00);
        check("R8", "still active", {7'd0, dma_active}, 8'd1);
        check("R8", "dir kept", {7'd0, dma_to_bus}, 8'd1);
        check("R8", "no err", {7'd0, start_err}, 8'd0);
        mode_bits = 8'h42;
        wr(3'd6, 8'h00);
        check("R8", "role kept", {7'd0, dma_target}, 8'd0);
        check("R8", "dir kept 2", {7'd0, dma_to_bus}, 8'd1);
        eop_end("R9");
    endtask

    task automatic t_mode_clear();
        mode_bits = 8'h02;
        wr(3'd7, 8'h00);
        check("R10", "started", {7'd0, dma_active}, 8'd1);
        @(negedge clk);
        mode_bits = 8'h00;
        @(negedge clk);
        check("R10", "active cleared", {7'd0, dma_active}, 8'd0);
        check("R10", "end_evt", {7'd0, end_evt}, 8'd1);
        check("R11", "req cleared", {7'd0, dma_req}, 8'd0);
        @(negedge clk);
        check("R10", "end_evt drops", {7'd0, end_evt}, 8'd0);
    endtask

    task automatic t_handshake();
        mode_bits = 8'h02;
        wr(3'd5, 8'h00);
        check("R11", "req up", {7'd0, dma_req}, 8'd1);
        @(negedge clk);
        check("R11", "req held", {7'd0, dma_req}, 8'd1);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        check("R11", "req after ack", {7'd0, dma_req}, 8'd0);
        check("R11", "active after ack", {7'd0, dma_active}, 8'd1);
        eop_end("R9");
    endtask

    task automatic t_block();
        mode_bits = 8'h82;
        wr(3'd5, 8'h00);
        check("R12", "block captured", {7'd0, dma_block}, 8'd1);
        @(negedge clk);
        mode_bits = 8'h02;
        repeat (2) @(negedge clk);
        check("R12", "block held", {7'd0, dma_block}, 8'd1);
        eop_end("R9");
        wr(3'd5, 8'h00);
        check("R12", "block clear", {7'd0, dma_block}, 8'd0);
        eop_end("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_send();
        t_trecv();
        t_irecv();
        t_data_ignored();
        t_prereq();
        t_read7();
        t_second_start();
        t_mode_clear();
        t_handshake();
        t_block();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule